// File: doc/BRIEF.md
# PCI I/O Window Base Decoder

This block keeps the configuration-space base registers for two I/O windows of a system-management PCI function: a 64-byte power-management window and a 16-byte SMBus host window. Configuration software writes and reads these registers one byte at a time. The block compares every 16-bit I/O address against both programmed windows. For each window it raises a hit and gives the offset of the access inside that window, so the register files behind each window can be selected directly.

Each window has a 32-bit base register. An enable bit, held in a separate configuration byte, gates the decode of that window. At reset the block loads the values that boot firmware would program, so both windows decode straight away at their default locations. Configuration accesses have no handshake. A write is accepted in the cycle it is presented, and read data is returned combinationally for the byte offset presented. The I/O address is compared in the same cycle it is applied. No interface applies back-pressure.

Top module: `pci_iowin_decoder`

## Requirements
- R1: After reset the configuration bytes read as follows. Offsets 0x40..0x43 give 01 40 00 00 and offsets 0x90..0x93 give 01 41 00 00. Offset 0x80 gives 0x01. Offset 0xD2 gives 0x09, which is enable bit 0 set and an interrupt-select field of 4 in bits 3:1. Offsets 0xD3..0xD6 give 0x00.
- R2: Bit 0 of the bytes at 0x40 and 0x90 always reads 1, marking the window as I/O space. This holds even after 0 is written to that bit.
- R3: The power-management window hits when io_addr[15:6] equals the base bits [15:6] taken from bytes 0x41:0x40, provided the window is enabled and that effective base is nonzero. On a hit, pm_offset equals io_addr[5:0]. Without a hit it is 0.
- R4: The SMBus window hits when io_addr[15:4] equals the base bits [15:4] taken from bytes 0x91:0x90, provided the window is enabled and that effective base is nonzero. On a hit, smb_offset equals io_addr[3:0]. Without a hit it is 0.
- R5: Bit 0 of the byte at 0x80 enables the power-management window. While that bit is clear, pm_hit stays low. The other bits of that byte do not affect decode.
- R6: Bit 0 of the byte at 0xD2 enables the SMBus window. While that bit is clear, smb_hit stays low.
- R7: A window whose masked base is zero never hits, whatever the I/O address.
- R8: A configuration write changes decode from the cycle after the write. In the cycle of the write, decode still uses the previous values.
- R9: Offsets outside 0x40..0x43, 0x80, 0x90..0x93 and 0xD2..0xD6 read as 0, and writes to them have no effect. The upper two bytes of each base register can be written and read back, but they do not affect decode.
- R10: Base bits below the window alignment are stored and read back as written, apart from bit 0 (see R2). They are ignored by the address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset for read and write |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for cfg_addr |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the power-management window |
| pm_offset | output | 6 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the SMBus window |
| smb_offset | output | 4 | Offset inside the SMBus window |

## Verification
The bench probes the last and first-beyond addresses of each window: 0x403F against 0x4040 for power management, and 0x122F against 0x1230 and 0x1210 for SMBus. A design with the wrong alignment mask would claim a neighbour's address or lose the top of its own window. A decoder that ignored the enable bit would keep hitting after bit 0 of 0x80 or 0xD2 was cleared. Writing zero to the marker bit checks that bit 0 still reads 1. Programming a zero base checks that address 0x0000 is not claimed. The bench also writes a base and presents a matching address in the same cycle. A design that bypassed the new value combinationally would hit one cycle early.

// File: rtl/pci_iowin_pkg.sv
`timescale 1ns/1ps
package pci_iowin_pkg;
  localparam int CFG_AW  = 8;
  localparam int DATA_W  = 8;
  localparam int IO_AW   = 16;
  localparam int BASE_W  = 32;

  // configuration-space layout (decoded by neighbouring software)
  localparam logic [CFG_AW-1:0] PM_BASE_OFS  = 8'h40;
  localparam logic [CFG_AW-1:0] PM_EN_OFS    = 8'h80;
  localparam logic [CFG_AW-1:0] SMB_BASE_OFS = 8'h90;
  localparam logic [CFG_AW-1:0] SMB_EN_OFS   = 8'hD2;
  localparam logic [CFG_AW-1:0] AUX_FIRST    = 8'hD3;
  localparam int                AUX_COUNT    = 4;

  // window sizes expressed as offset widths
  localparam int PM_ALIGN  = 6;
  localparam int SMB_ALIGN = 4;

  // firmware-style defaults
  localparam logic [BASE_W-1:0] PM_BASE_RST  = 32'h0000_4000;
  localparam logic [BASE_W-1:0] SMB_BASE_RST = 32'h0000_4100;
  localparam logic [2:0]        SMB_IRQ_SEL_RST = 3'd4;
  localparam logic [DATA_W-1:0] PM_EN_RST    = 8'h01;
  localparam logic [DATA_W-1:0] SMB_EN_RST   = {4'b0000, SMB_IRQ_SEL_RST, 1'b1};
endpackage

// File: rtl/iowin_range_cmp.sv
`timescale 1ns/1ps
module iowin_range_cmp #(
  parameter int IO_AW      = 16,
  parameter int ALIGN_BITS = 6,
  localparam int PAGE_W    = IO_AW - ALIGN_BITS
) (
  input  logic [PAGE_W-1:0]     win_page,
  input  logic [IO_AW-1:0]      io_addr,
  output logic                  hit,
  output logic [ALIGN_BITS-1:0] offset
);
  logic page_match;
  logic page_valid;

  assign page_valid = |win_page;
  assign page_match = (io_addr[IO_AW-1:ALIGN_BITS] == win_page);
  assign hit        = page_valid && page_match;
  assign offset     = hit ? io_addr[ALIGN_BITS-1:0] : '0;
endmodule

// File: rtl/iowin_window.sv
`timescale 1ns/1ps
module iowin_window #(
  parameter int                IO_AW      = 16,
  parameter int                ALIGN_BITS = 6,
  parameter int                BASE_W     = 32,
  parameter logic [7:0]        BASE_OFS   = 8'h40,
  parameter logic [7:0]        EN_OFS     = 8'h80,
  parameter logic [BASE_W-1:0] BASE_RST   = '0,
  parameter logic [7:0]        EN_RST     = 8'h00,
  localparam int               NBYTES     = BASE_W / 8,
  localparam int               PAGE_W     = IO_AW - ALIGN_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic [IO_AW-1:0]      io_addr,
  output logic                  rd_sel,
  output logic [7:0]            rd_data,
  output logic                  hit,
  output logic [ALIGN_BITS-1:0] offset
);
  logic [BASE_W-1:0] base_q;
  logic [7:0]        en_q;
  logic [NBYTES-1:0] byte_sel;
  logic              en_sel;
  logic [PAGE_W-1:0] win_page;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    assign byte_sel[b] = (cfg_addr == BASE_OFS + 8'(b));
  end
  assign en_sel = (cfg_addr == EN_OFS);
  assign rd_sel = (|byte_sel) || en_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      en_q   <= EN_RST;
    end else if (cfg_we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (byte_sel[b]) base_q[8*b +: 8] <= cfg_wdata;
      end
      if (en_sel) en_q <= cfg_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (byte_sel[b]) begin
        rd_data = base_q[8*b +: 8];
        if (b == 0) rd_data[0] = 1'b1;  // I/O-space marker
      end
    end
    if (en_sel) rd_data = en_q;
  end

  // disabled window presents a zero page, which never matches
  assign win_page = en_q[0] ? base_q[IO_AW-1:ALIGN_BITS] : '0;

  iowin_range_cmp #(
    .IO_AW      (IO_AW),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_cmp (
    .win_page (win_page),
    .io_addr  (io_addr),
    .hit      (hit),
    .offset   (offset)
  );
endmodule

// File: rtl/iowin_aux_bytes.sv
`timescale 1ns/1ps
module iowin_aux_bytes #(
  parameter logic [7:0] FIRST = 8'hD3,
  parameter int         COUNT = 4,
  localparam int        W     = 8 * COUNT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic       rd_sel,
  output logic [7:0] rd_data
);
  logic [W-1:0]     regs_q;
  logic [COUNT-1:0] sel;

  for (genvar i = 0; i < COUNT; i++) begin : g_sel
    assign sel[i] = (cfg_addr == FIRST + 8'(i));
  end
  assign rd_sel = |sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < COUNT; i++) begin
        if (sel[i]) regs_q[8*i +: 8] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (sel[i]) rd_data = regs_q[8*i +: 8];
    end
  end
endmodule

// File: rtl/pci_iowin_decoder.sv
`timescale 1ns/1ps
module pci_iowin_decoder
  import pci_iowin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [15:0] io_addr,
  output logic        pm_hit,
  output logic [5:0]  pm_offset,
  output logic        smb_hit,
  output logic [3:0]  smb_offset
);
  logic       pm_rd_sel, smb_rd_sel, aux_rd_sel;
  logic [7:0] pm_rd_data, smb_rd_data, aux_rd_data;

  iowin_window #(
    .IO_AW      (IO_AW),
    .ALIGN_BITS (PM_ALIGN),
    .BASE_W     (BASE_W),
    .BASE_OFS   (PM_BASE_OFS),
    .EN_OFS     (PM_EN_OFS),
    .BASE_RST   (PM_BASE_RST),
    .EN_RST     (PM_EN_RST)
  ) u_pm_win (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .io_addr,
    .rd_sel  (pm_rd_sel),
    .rd_data (pm_rd_data),
    .hit     (pm_hit),
    .offset  (pm_offset)
  );

  iowin_window #(
    .IO_AW      (IO_AW),
    .ALIGN_BITS (SMB_ALIGN),
    .BASE_W     (BASE_W),
    .BASE_OFS   (SMB_BASE_OFS),
    .EN_OFS     (SMB_EN_OFS),
    .BASE_RST   (SMB_BASE_RST),
    .EN_RST     (SMB_EN_RST)
  ) u_smb_win (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .io_addr,
    .rd_sel  (smb_rd_sel),
    .rd_data (smb_rd_data),
    .hit     (smb_hit),
    .offset  (smb_offset)
  );

  iowin_aux_bytes #(
    .FIRST (AUX_FIRST),
    .COUNT (AUX_COUNT)
  ) u_aux (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .rd_sel  (aux_rd_sel),
    .rd_data (aux_rd_data)
  );

  always_comb begin
    if (pm_rd_sel)       cfg_rdata = pm_rd_data;
    else if (smb_rd_sel) cfg_rdata = smb_rd_data;
    else if (aux_rd_sel) cfg_rdata = aux_rd_data;
    else                 cfg_rdata = '0;
  end
endmodule

// File: rtl/pci_iowin_decoder_chk.sv
`timescale 1ns/1ps
module pci_iowin_decoder_chk
  import pci_iowin_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] io_addr,
  input logic        pm_hit,
  input logic [5:0]  pm_offset,
  input logic        smb_hit,
  input logic [3:0]  smb_offset
);
  a_r2_io_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == PM_BASE_OFS || cfg_addr == SMB_BASE_OFS) |-> cfg_rdata[0]);

  a_r5_pm_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == PM_EN_OFS && !cfg_wdata[0]) |=> !pm_hit);

  a_r6_smb_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == SMB_EN_OFS && !cfg_wdata[0]) |=> !smb_hit);

  a_r7_pm_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> (io_addr[15:6] != '0));

  a_r7_smb_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> (io_addr[15:4] != '0));

  a_r8_decode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(io_addr)) |->
      ($stable(pm_hit) && $stable(smb_hit) && $stable(pm_offset) && $stable(smb_offset)));
endmodule

bind pci_iowin_decoder pci_iowin_decoder_chk u_chk (.*);

// File: tb/pci_iowin_decoder_tb_top.sv
`timescale 1ns/1ps
module pci_iowin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = 16'h0000;
  logic        pm_hit;
  logic [5:0]  pm_offset;
  logic        smb_hit;
  logic [3:0]  smb_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_iowin_decoder dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .io_addr, .pm_hit, .pm_offset, .smb_hit, .smb_offset
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m [256];

  function automatic bit is_impl(logic [7:0] a);
    return (a >= 8'h40 && a <= 8'h43) || a == 8'h80 ||
           (a >= 8'h90 && a <= 8'h93) || (a >= 8'hD2 && a <= 8'hD6);
  endfunction

  task automatic m_reset();
    foreach (m[i]) m[i] = 8'h00;
    m[8'h41] = 8'h40;
    m[8'h91] = 8'h41;
    m[8'h80] = 8'h01;
    m[8'hD2] = 8'h09;
  endtask

  function automatic logic [7:0] m_read(logic [7:0] a);
    logic [7:0] v;
    if (!is_impl(a)) return 8'h00;
    v = m[a];
    if (a == 8'h40 || a == 8'h90) v[0] = 1'b1;
    return v;
  endfunction

  function automatic bit m_hit(logic [15:0] io, logic [7:0] en_a, logic [7:0] lo_a, logic [15:0] mask);
    logic [15:0] base;
    base = {m[lo_a + 8'd1], m[lo_a]} & mask;
    return m[en_a][0] && base != 16'h0 && ((io & mask) == base);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial m_reset();

  // per-clock comparison against the model
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (cfg_we && is_impl(cfg_addr)) m[cfg_addr] = cfg_wdata;
    #3;
    if (rst_n) begin
      bit ph, sh;
      ph = m_hit(io_addr, 8'h80, 8'h40, 16'hFFC0);
      sh = m_hit(io_addr, 8'hD2, 8'h90, 16'hFFF0);
      chk("R9 scoreboard cfg_rdata", cfg_rdata, m_read(cfg_addr));
      chk("R3 scoreboard pm_hit", pm_hit, ph);
      chk("R3 scoreboard pm_offset", pm_offset, ph ? io_addr[5:0] : 0);
      chk("R4 scoreboard smb_hit", smb_hit, sh);
      chk("R4 scoreboard smb_offset", smb_offset, sh ? io_addr[3:0] : 0);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic io_chk(string req, logic [15:0] io, bit ph, int po, bit sh, int so);
    @(negedge clk);
    io_addr = io;
    #1;
    chk({req, " pm_hit"}, pm_hit, ph);
    chk({req, " pm_offset"}, pm_offset, po);
    chk({req, " smb_hit"}, smb_hit, sh);
    chk({req, " smb_offset"}, smb_offset, so);
  endtask

  task automatic reset_values(string req);
    rd_chk(req, 8'h40, 8'h01); rd_chk(req, 8'h41, 8'h40);
    rd_chk(req, 8'h42, 8'h00); rd_chk(req, 8'h43, 8'h00);
    rd_chk(req, 8'h90, 8'h01); rd_chk(req, 8'h91, 8'h41);
    rd_chk(req, 8'h92, 8'h00); rd_chk(req, 8'h93, 8'h00);
    rd_chk(req, 8'h80, 8'h01); rd_chk(req, 8'hD2, 8'h09);
    for (int a = 8'hD3; a <= 8'hD6; a++) rd_chk(req, 8'(a), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reset_values("R1 reset");
    io_chk("R3 default pm", 16'h4005, 1, 5, 0, 0);
    io_chk("R3 pm top", 16'h403F, 1, 6'h3F, 0, 0);
    io_chk("R3 pm beyond", 16'h4040, 0, 0, 0, 0);
    io_chk("R4 default smb", 16'h4103, 0, 0, 1, 3);
    io_chk("R4 smb beyond", 16'h4110, 0, 0, 0, 0);

    // R2 marker bit
    cfg_write(8'h40, 8'h00);
    rd_chk("R2 pm marker", 8'h40, 8'h01);
    cfg_write(8'h90, 8'h00);
    rd_chk("R2 smb marker", 8'h90, 8'h01);

    // R10 low base bits stored but ignored
    cfg_write(8'h40, 8'h3F);
    rd_chk("R10 pm low bits", 8'h40, 8'h3F);
    io_chk("R10 pm decode", 16'h4000, 1, 0, 0, 0);

    // R8 write timing
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h41; cfg_wdata = 8'h50; io_addr = 16'h5000;
    #1;
    chk("R8 same cycle old base", pm_hit, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R8 next cycle new base", pm_hit, 1);

    // R5 pm enable
    cfg_write(8'h80, 8'hFE);
    io_chk("R5 pm disabled", 16'h5000, 0, 0, 0, 0);
    cfg_write(8'h80, 8'h01);
    io_chk("R5 pm re-enabled", 16'h5012, 1, 6'h12, 0, 0);

    // R6 smb enable
    cfg_write(8'hD2, 8'h08);
    io_chk("R6 smb disabled", 16'h4100, 0, 0, 0, 0);
    rd_chk("R6 enable byte readback", 8'hD2, 8'h08);
    cfg_write(8'hD2, 8'h09);
    io_chk("R6 smb re-enabled", 16'h4107, 0, 0, 1, 7);

    // R9 unimplemented and upper bytes
    rd_chk("R9 hole read", 8'h44, 8'h00);
    cfg_write(8'h44, 8'hAA);
    rd_chk("R9 hole write ignored", 8'h44, 8'h00);
    rd_chk("R9 offset zero", 8'h00, 8'h00);
    cfg_write(8'h42, 8'hFF);
    rd_chk("R9 upper byte readback", 8'h42, 8'hFF);
    io_chk("R9 upper byte no decode effect", 16'h5001, 1, 1, 0, 0);
    cfg_write(8'hD5, 8'h5A);
    rd_chk("R9 aux byte", 8'hD5, 8'h5A);

    // R7 zero base
    cfg_write(8'h40, 8'h01);
    cfg_write(8'h41, 8'h00);
    io_chk("R7 zero base addr 0", 16'h0000, 0, 0, 0, 0);
    io_chk("R7 zero base addr 10", 16'h0010, 0, 0, 0, 0);

    // R4 relocated SMBus window
    cfg_write(8'h90, 8'h28);
    cfg_write(8'h91, 8'h12);
    io_chk("R4 smb relocated top", 16'h122F, 0, 0, 1, 4'hF);
    io_chk("R4 smb relocated beyond", 16'h1230, 0, 0, 0, 0);
    io_chk("R4 smb relocated below", 16'h1210, 0, 0, 0, 0);

    // R1 reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_values("R1 re-reset");
    io_chk("R3 after re-reset", 16'h4021, 1, 6'h21, 0, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule